// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the command register a local interrupt controller uses to send inter-processor interrupts. Software builds a 64-bit command word that holds a vector, a delivery mode, a destination mode, level and trigger bits, a destination shorthand and a destination. Writing the launching part of that word sends exactly one message on a valid/ready output port toward the interrupt fabric. While the message is outstanding, a read-only busy bit in the command word reads 1. A small error status register records rejected sends, and a logical-ID register shows the clustered logical identity derived from the local ID.

Two access styles are supported, chosen by a static `ext_mode` pin. In the 32-bit style, the command is split into a low half and a high half. The high half carries an 8-bit destination and only stores it. The low half stores the control fields and fires the send, so software writes the high half first. In the 64-bit style, one write at the command address loads a 32-bit destination from the upper word and fires the send at the same time.

Register addresses (`bus_addr`): 0 is the command word (its low half in the 32-bit style), 1 is the command high half (32-bit style only), 2 is the error status, and 3 is the logical ID. In the 32-bit style, write data and read data use bits [31:0] of the bus.

Top module: `ipi_cmd_reg`

## Requirements
- R1: The command low half reads back as follows: vector in [7:0], delivery mode in [10:8], destination mode in [11] (1 = logical), busy in [12], level in [14], trigger in [15] (1 = level), shorthand in [19:18]. All other bits read 0. The value written to bit 12 is ignored; bit 12 always shows the busy state.
- R2: In the 32-bit style, a write to address 1 stores wdata[31:24] as the 8-bit destination, which reads back at [31:24] of address 1. This write launches nothing and is dropped while busy.
- R3: In the 32-bit style, a write to address 0 while idle launches a send. msg_valid is 1 from the clock edge that takes the write, and the message carries the written fields.
- R4: In the 64-bit style, a single write to address 0 stores wdata[63:32] as the 32-bit destination and launches the send. Address 0 reads back the destination in [63:32].
- R5: Once launched, msg_valid and the busy bit stay 1, with the message fields unchanged, until an edge with msg_ready high. Both are 0 after that edge.
- R6: When the shorthand is 00, msg_dest is the stored destination: the 8-bit value zero-extended in the 32-bit style, or the 32-bit value in the 64-bit style. When the shorthand is 01, 10 or 11, msg_dest is 0.
- R7: A launching write whose delivery mode is 011 stores its fields but sends nothing. It sets error status bit 5, and busy stays 0.
- R8: A write to address 0 while busy is dropped. The message and the stored fields are unchanged, and error status bit 2 is set.
- R9: Any write to address 2 clears every error status bit, whatever the data.
- R10: In the 64-bit style, address 3 reads {local_id[19:4], a 16-bit one-hot with bit local_id[3:0] set}. In the 32-bit style it reads 0.
- R11: Vector, delivery mode, destination mode, level and trigger appear on the message exactly as written, including INIT with level trigger and level 0.
- R12: After reset, the command word, destination, error status and msg_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | 1 selects the 64-bit access style (static) |
| local_id | input | 32 | Local controller ID, source of the logical ID |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| msg_valid | output | 1 | Outgoing interrupt message is valid |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_level | output | 1 | Message level bit |
| msg_trigger | output | 1 | Message trigger, 1 = level |
| msg_shorthand | output | 2 | Message destination shorthand |
| msg_dest | output | 32 | Resolved destination, 0 under a shorthand |

## Verification
A corrupted busy flag shows up at once in two places: msg_valid and bit 12 of address 0. A busy flag stuck high also turns the next launch into a bit-2 error visible at address 2. A wrong stored field shows on the message port and on the readback of address 0 in the cycle after the write. A mis-resolved destination or a lost shorthand shows on msg_dest in that same cycle. Because the reference model is compared on every clock, any divergence is reported within one cycle of the edge that caused it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWPRI  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSVD    = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_UNDEF   = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    dmode_e     dmode;
    logic       logical;
    logic       level;
    logic       trigger;
    shorthand_e sh;
  } cmd_t;

  // Command word bit positions (decoded by software and neighbours)
  localparam int VEC_LSB   = 0;
  localparam int DM_LSB    = 8;
  localparam int LOGIC_BIT = 11;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;

  // Error status bits
  localparam int ESR_SEND_ACCEPT = 2;
  localparam int ESR_ILLEGAL     = 5;

  // Register addresses
  localparam logic [1:0] ADDR_CMD_LO = 2'd0;
  localparam logic [1:0] ADDR_CMD_HI = 2'd1;
  localparam logic [1:0] ADDR_ESR    = 2'd2;
  localparam logic [1:0] ADDR_LDR    = 2'd3;

endpackage

// File: rtl/ipi_reset_sync.sv
module ipi_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
  import ipi_pkg::*;
#(
  parameter int DEST_W     = 32,
  parameter int LEG_DEST_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_we,
  input  logic                  hi_we,
  input  logic                  ext_mode,
  input  cmd_t                  cmd_in,
  input  logic [DEST_W-1:0]     dest_ext_in,
  input  logic [LEG_DEST_W-1:0] dest_leg_in,
  output cmd_t                  cmd_q,
  output logic [DEST_W-1:0]     dest_q
);

  cmd_t              cmd_d;
  logic [DEST_W-1:0] dest_d;
  logic              cmd_en;
  logic              dest_en;

  always_comb begin
    cmd_en  = lo_we;
    dest_en = (lo_we && ext_mode) || hi_we;
    cmd_d   = cmd_q;
    dest_d  = dest_q;
    if (lo_we) begin
      cmd_d = cmd_in;
      if (ext_mode) begin
        dest_d = dest_ext_in;
      end
    end
    if (hi_we) begin
      dest_d                   = '0;
      dest_d[LEG_DEST_W-1:0]   = dest_leg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= cmd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (dest_en) begin
      dest_q <= dest_d;
    end
  end

endmodule

// File: rtl/ipi_send_ctrl.sv
module ipi_send_ctrl
  import ipi_pkg::*;
#(
  parameter int ESR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_req,
  input  dmode_e           req_dmode,
  input  logic             esr_clr,
  input  logic             msg_ready,
  output logic             busy_q,
  output logic             accept,
  output logic [ESR_W-1:0] esr_q
);

  logic             busy_d;
  logic             busy_en;
  logic [ESR_W-1:0] esr_d;
  logic             esr_en;
  logic             illegal;
  logic             collide;
  logic             handshake;

  always_comb begin
    accept    = launch_req && !busy_q;
    collide   = launch_req && busy_q;
    illegal   = accept && (req_dmode == DM_RSVD);
    handshake = busy_q && msg_ready;

    busy_en = (accept && !illegal) || handshake;
    busy_d  = accept && !illegal;

    esr_en = esr_clr || collide || illegal;
    esr_d  = esr_q;
    if (esr_clr) begin
      esr_d = '0;
    end
    if (collide) begin
      esr_d[ESR_SEND_ACCEPT] = 1'b1;
    end
    if (illegal) begin
      esr_d[ESR_ILLEGAL] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esr_q <= '0;
    end else if (esr_en) begin
      esr_q <= esr_d;
    end
  end

endmodule

// File: rtl/ipi_logical_id.sv
module ipi_logical_id #(
  parameter int ID_W      = 32,
  parameter int SUB_W     = 4,
  parameter int CLUSTER_W = 16
) (
  input  logic [ID_W-1:0] local_id,
  output logic [ID_W-1:0] logical_id
);

  localparam int ONEHOT_W = 1 << SUB_W;

  logic [ONEHOT_W-1:0]  onehot;
  logic [CLUSTER_W-1:0] cluster;

  genvar g;
  generate
    for (g = 0; g < ONEHOT_W; g++) begin : g_onehot
      assign onehot[g] = (local_id[SUB_W-1:0] == SUB_W'(g));
    end
  endgenerate

  assign cluster    = local_id[SUB_W +: CLUSTER_W];
  assign logical_id = {cluster, onehot};

endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ID_W        = 32,
  parameter int LEG_DEST_W  = 8,
  parameter int ESR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [ID_W-1:0]   local_id,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dmode,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [1:0]        msg_shorthand,
  output logic [ID_W-1:0]   msg_dest
);

  localparam int HALF_W = DATA_W / 2;

  logic             rst_int_n;
  logic             wr;
  logic             launch_req;
  logic             esr_clr;
  logic             hi_req;
  logic             lo_we;
  logic             hi_we;
  logic             busy_q;
  logic             accept;
  logic [ESR_W-1:0] esr_q;
  cmd_t             wr_cmd;
  cmd_t             cmd_q;
  logic [ID_W-1:0]  dest_q;
  logic [ID_W-1:0]  ldr;
  logic [HALF_W-1:0] lo_word;
  logic             unused_bits;

  ipi_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Bus decode
  always_comb begin
    wr         = bus_req && bus_we;
    launch_req = wr && (bus_addr == ADDR_CMD_LO);
    esr_clr    = wr && (bus_addr == ADDR_ESR);
    hi_req     = wr && (bus_addr == ADDR_CMD_HI) && !ext_mode;
    lo_we      = accept;
    hi_we      = hi_req && !busy_q;

    wr_cmd.vector  = bus_wdata[VEC_LSB +: 8];
    wr_cmd.dmode   = dmode_e'(bus_wdata[DM_LSB +: 3]);
    wr_cmd.logical = bus_wdata[LOGIC_BIT];
    wr_cmd.level   = bus_wdata[LEVEL_BIT];
    wr_cmd.trigger = bus_wdata[TRIG_BIT];
    wr_cmd.sh      = shorthand_e'(bus_wdata[SH_LSB +: 2]);
  end

  assign unused_bits = ^{bus_wdata[HALF_W-LEG_DEST_W-1:SH_LSB+2],
                         bus_wdata[SH_LSB-1:TRIG_BIT+1],
                         bus_wdata[BUSY_BIT+1], bus_wdata[BUSY_BIT],
                         local_id[ID_W-1:20]};

  ipi_send_ctrl #(.ESR_W(ESR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .launch_req (launch_req),
    .req_dmode  (wr_cmd.dmode),
    .esr_clr    (esr_clr),
    .msg_ready  (msg_ready),
    .busy_q     (busy_q),
    .accept     (accept),
    .esr_q      (esr_q)
  );

  ipi_cmd_store #(.DEST_W(ID_W), .LEG_DEST_W(LEG_DEST_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lo_we       (lo_we),
    .hi_we       (hi_we),
    .ext_mode    (ext_mode),
    .cmd_in      (wr_cmd),
    .dest_ext_in (bus_wdata[DATA_W-1:HALF_W]),
    .dest_leg_in (bus_wdata[HALF_W-1 -: LEG_DEST_W]),
    .cmd_q       (cmd_q),
    .dest_q      (dest_q)
  );

  ipi_logical_id #(.ID_W(ID_W)) u_ldr (
    .local_id   (local_id),
    .logical_id (ldr)
  );

  // Read path
  always_comb begin
    lo_word                   = '0;
    lo_word[VEC_LSB +: 8]     = cmd_q.vector;
    lo_word[DM_LSB +: 3]      = cmd_q.dmode;
    lo_word[LOGIC_BIT]        = cmd_q.logical;
    lo_word[BUSY_BIT]         = busy_q;
    lo_word[LEVEL_BIT]        = cmd_q.level;
    lo_word[TRIG_BIT]         = cmd_q.trigger;
    lo_word[SH_LSB +: 2]      = cmd_q.sh;

    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CMD_LO: begin
        bus_rdata[HALF_W-1:0] = lo_word;
        if (ext_mode) begin
          bus_rdata[DATA_W-1:HALF_W] = dest_q;
        end
      end
      ADDR_CMD_HI: begin
        if (!ext_mode) begin
          bus_rdata[HALF_W-1 -: LEG_DEST_W] = dest_q[LEG_DEST_W-1:0];
        end
      end
      ADDR_ESR: begin
        bus_rdata[ESR_W-1:0] = esr_q;
      end
      default: begin
        if (ext_mode) begin
          bus_rdata[ID_W-1:0] = ldr;
        end
      end
    endcase
  end

  // Message port
  always_comb begin
    msg_valid     = busy_q;
    msg_vector    = cmd_q.vector;
    msg_dmode     = cmd_q.dmode;
    msg_logical   = cmd_q.logical;
    msg_level     = cmd_q.level;
    msg_trigger   = cmd_q.trigger;
    msg_shorthand = cmd_q.sh;
    if (cmd_q.sh != SH_NONE) begin
      msg_dest = '0;
    end else if (ext_mode) begin
      msg_dest = dest_q;
    end else begin
      msg_dest                 = '0;
      msg_dest[LEG_DEST_W-1:0] = dest_q[LEG_DEST_W-1:0];
    end
  end

endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_mode,
  input logic        bus_req,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [63:0] bus_wdata,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [7:0]  msg_vector,
  input logic [2:0]  msg_dmode,
  input logic [1:0]  msg_shorthand,
  input logic [31:0] msg_dest,
  input logic [7:0]  esr
);

  logic launch;
  assign launch = bus_req && bus_we && (bus_addr == 2'd0);

  // R5
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid);

  // R5
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> $stable(msg_vector) && $stable(msg_dmode) && $stable(msg_shorthand));

  // R5
  handshake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !msg_valid && (bus_wdata[10:8] != 3'd3) |=> msg_valid && (msg_vector == $past(bus_wdata[7:0])));

  // R4
  ext_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && ext_mode && !msg_valid && (bus_wdata[10:8] != 3'd3) && (bus_wdata[19:18] == 2'd0)
    |=> msg_dest == $past(bus_wdata[63:32]));

  // R7
  illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && !msg_valid && (bus_wdata[10:8] == 3'd3) |=> !msg_valid && esr[5]);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch && msg_valid |=> esr[2]);

  // R9
  esr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && (bus_addr == 2'd2) |=> esr == 8'h00);

endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .ext_mode      (ext_mode),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_vector    (msg_vector),
  .msg_dmode     (msg_dmode),
  .msg_shorthand (msg_shorthand),
  .msg_dest      (msg_dest),
  .esr           (esr_q)
);

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0;
  logic [31:0] local_id = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        msg_ready = 1'b0;
  logic [63:0] bus_rdata;
  logic        msg_valid;
  logic [7:0]  msg_vector;
  logic [2:0]  msg_dmode;
  logic        msg_logical, msg_level, msg_trigger;
  logic [1:0]  msg_shorthand;
  logic [31:0] msg_dest;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  ipi_cmd_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .local_id(local_id),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_logical(msg_logical),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand),
    .msg_dest(msg_dest)
  );

  // Behavioural reference model
  logic        m_busy;
  logic [7:0]  m_vec;
  logic [2:0]  m_dm;
  logic        m_log, m_lvl, m_trg;
  logic [1:0]  m_sh;
  logic [31:0] m_dest;
  logic [7:0]  m_esr;
  int          m_rcnt = 0;

  function automatic logic [31:0] exp_ldr();
    logic [31:0] c;
    c = (local_id >> 4) & 32'h0000_FFFF;
    return (c << 16) | (32'd1 << local_id[3:0]);
  endfunction

  function automatic logic [63:0] exp_rd();
    case (bus_addr)
      2'd0: return {(ext_mode ? m_dest : 32'h0), 12'h0, m_sh, 2'b00, m_trg, m_lvl,
                    1'b0, m_busy, m_log, m_dm, m_vec};
      2'd1: return ext_mode ? 64'h0 : {32'h0, m_dest[7:0], 24'h0};
      2'd2: return {56'h0, m_esr};
      default: return ext_mode ? {32'h0, exp_ldr()} : 64'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_dest();
    if (m_sh != 2'd0) return 32'h0;
    return ext_mode ? m_dest : {24'h0, m_dest[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic hs;
    logic go;
    if (!rst_n || m_rcnt < 2) begin
      m_busy = 0; m_vec = 0; m_dm = 0; m_log = 0; m_lvl = 0; m_trg = 0;
      m_sh = 0; m_dest = 0; m_esr = 0;
      if (rst_n) m_rcnt++; else m_rcnt = 0;
    end else begin
      hs = m_busy && msg_ready;
      go = 1'b0;
      if (bus_req && bus_we) begin
        case (bus_addr)
          2'd0: begin
            if (m_busy) m_esr[2] = 1'b1;
            else begin
              m_vec = bus_wdata[7:0];   m_dm  = bus_wdata[10:8];
              m_log = bus_wdata[11];    m_lvl = bus_wdata[14];
              m_trg = bus_wdata[15];    m_sh  = bus_wdata[19:18];
              if (ext_mode) m_dest = bus_wdata[63:32];
              if (bus_wdata[10:8] == 3'd3) m_esr[5] = 1'b1;
              else go = 1'b1;
            end
          end
          2'd1: if (!ext_mode && !m_busy) m_dest = {24'h0, bus_wdata[31:24]};
          2'd2: m_esr = 8'h0;
          default: ;
        endcase
      end
      m_busy = go ? 1'b1 : (m_busy && !hs);
    end
    #2;
    chk("R5 msg_valid vs model", {63'h0, msg_valid}, {63'h0, m_busy});
    chk("R11 message fields vs model",
        {40'h0, msg_vector, msg_dmode, msg_logical, msg_level, msg_trigger, msg_shorthand},
        {40'h0, m_vec, m_dm, m_log, m_lvl, m_trg, m_sh});
    chk("R6 msg_dest vs model", {32'h0, msg_dest}, {32'h0, exp_dest()});
    case (bus_addr)
      2'd0: chk("R1 command readback vs model", bus_rdata, exp_rd());
      2'd1: chk("R2 high half readback vs model", bus_rdata, exp_rd());
      2'd2: chk("R9 error status readback vs model", bus_rdata, exp_rd());
      default: chk("R10 logical id readback vs model", bus_rdata, exp_rd());
    endcase
  end

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [63:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic accept_msg();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    rd_chk("R12 command after reset", 2'd0, 64'h0);
    rd_chk("R12 error status after reset", 2'd2, 64'h0);
    chk("R12 msg_valid after reset", {63'h0, msg_valid}, 64'h0);

    // R2 / R3: legacy destination then launch (bit 12 written as 1)
    wr(2'd1, 64'h0000_0000_5A00_0000);
    chk("R2 high write does not launch", {63'h0, msg_valid}, 64'h0);
    wr(2'd0, 64'h0000_0000_0000_5031);
    chk("R3 msg_valid after low write", {63'h0, msg_valid}, 64'h1);
    chk("R3 msg_vector", {56'h0, msg_vector}, 64'h31);
    chk("R6 legacy destination", {32'h0, msg_dest}, 64'h5A);
    rd_chk("R5 busy bit while pending", 2'd0, 64'h5031);
    rd_chk("R2 high half readback", 2'd1, 64'h5A00_0000);

    // R8 launch while busy
    wr(2'd0, 64'h0000_0000_0000_0044);
    rd_chk("R8 send-accept error bit", 2'd2, 64'h04);
    chk("R8 message unchanged", {56'h0, msg_vector}, 64'h31);

    // R5 handshake; R1 bit 12 write ignored
    accept_msg();
    chk("R5 valid clears after accept", {63'h0, msg_valid}, 64'h0);
    rd_chk("R1 readback idle, bit 12 ignored", 2'd0, 64'h4031);

    // R9 clear with nonzero data
    wr(2'd2, 64'hFF);
    rd_chk("R9 error status cleared", 2'd2, 64'h0);

    // R6 shorthand all-including-self
    wr(2'd0, 64'h0000_0000_0008_0022);
    chk("R6 dest zero under shorthand", {32'h0, msg_dest}, 64'h0);
    chk("R6 shorthand forwarded", {62'h0, msg_shorthand}, 64'h2);
    accept_msg();

    // R7 reserved delivery mode
    wr(2'd0, 64'h0000_0000_0000_0377);
    chk("R7 no send for reserved mode", {63'h0, msg_valid}, 64'h0);
    rd_chk("R7 illegal-send bit", 2'd2, 64'h20);
    wr(2'd2, 64'h0);

    // R4 extended single write
    ext_mode = 1'b1;
    wr(2'd0, 64'h1234_5678_0000_0855);
    chk("R4 launched in extended style", {63'h0, msg_valid}, 64'h1);
    chk("R4 32-bit destination", {32'h0, msg_dest}, 64'h1234_5678);
    chk("R11 logical destination mode", {63'h0, msg_logical}, 64'h1);
    rd_chk("R4 readback with destination", 2'd0, 64'h1234_5678_0000_1855);
    accept_msg();

    // R10 logical ID
    local_id = 32'h000A_BC07;
    rd_chk("R10 logical id extended", 2'd3, 64'hABC0_0080);
    ext_mode = 1'b0;
    rd_chk("R10 logical id legacy reads zero", 2'd3, 64'h0);

    // R11 INIT de-assert with level trigger
    wr(2'd0, 64'h0000_0000_0000_8500);
    chk("R11 INIT mode", {61'h0, msg_dmode}, 64'h5);
    chk("R11 level trigger", {63'h0, msg_trigger}, 64'h1);
    chk("R11 level bit zero", {63'h0, msg_level}, 64'h0);
    accept_msg();

    // Random traffic, model compared on every clock
    for (int phase = 0; phase < 2; phase++) begin
      @(negedge clk);
      bus_req = 1'b0; msg_ready = 1'b1;
      repeat (2) @(negedge clk);
      ext_mode = (phase == 1);
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        bus_req   = ($urandom % 3) == 0;
        bus_we    = ($urandom % 4) != 0;
        bus_addr  = 2'($urandom);
        bus_wdata = {$urandom, $urandom};
        local_id  = $urandom;
        msg_ready = ($urandom % 4) == 0;
      end
    end
    @(negedge clk);
    bus_req = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule